// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Output Port

This block is the digital read-out side of a 24-bit sigma-delta converter. A parameterised conversion timer stands in for the modulator and filter. Each time a conversion ends, the timer loads the parallel result word into an output shift register. A single output pin carries both a ready flag and the serial data. The pin idles high, drops low when a fresh word is waiting, presents the word MSB first on the serial clock, and returns high once the word has been read. Before each register update the pin is forced high for a short blanking window, so that no read can overlap the update. A result that has not been read, or that has only been partly read, is dropped at that point.

The active-low select input does two jobs. While it is low, the timer converts back to back. While it is high, the block is in standby: any conversion is aborted, the held word is discarded, and both the data pin and the clock pin are released to high impedance through their enable outputs. A mode input picks one of two read-out styles. In self-clocked mode the block drives the serial clock and produces 24 pulses after a short ready interval. In externally clocked mode the clock comes from outside, passes through a synchroniser in the `clk` domain, and may arrive in one burst or in several groups.

Top module: `sdo_serial_port`

## Requirements
- R1: While `cs_n` is high, `dout_oe` and `sclk_oe` are low, the held word is discarded and the data register is set high. After `cs_n` falls again, `dout` stays high until the first load of the new conversion.
- R2: With `cs_n` low, a word is loaded on the `CONV_CYCLES`-th rising `clk` edge after `cs_n` falls, and on every `CONV_CYCLES`-th edge after that, without a gap.
- R3: On the edge that loads a word, `dout` goes low, and it stays low until the first falling serial clock edge.
- R4: Each falling serial clock edge puts the next bit of the word on `dout`, MSB first, and `dout` holds that bit through the following rising edge.
- R5: When the rising edge that completes the 24th bit is detected, `dout` goes high, and it stays high until the next load whatever the clock does.
- R6: For `BLANK_CYCLES` cycles before each load, `dout` is forced high and any unread or partly read word is dropped. Serial clock edges in this window have no effect on the next word's read-out.
- R7: In self-clocked mode (`slave_mode`=0), `sclk_oe` equals `!cs_n`. After a load, `dout` stays low with `sclk_out` high for `RDY_HOLD` cycles. Then 24 clock pulses follow, each phase one `clk` cycle long. `sclk_out` idles high.
- R8: In externally clocked mode (`slave_mode`=1), `sclk_oe` is low and `sclk_in` is sampled through a two-stage synchroniser. Each level of `sclk_in` must last at least three `clk` cycles. A word read in one burst and a word read in groups with arbitrary high gaps between them give the same bits.
- R9: Raising `cs_n` in the middle of a read drops both output enables in the same cycle. After `cs_n` is lowered again, no word appears before a full conversion period.
- R10: A read abandoned partway is dropped at the next blanking window. The next word is then read from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock; each serial clock phase in self-clocked mode is one period |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; high = standby and abort |
| slave_mode | input | 1 | 0 = block drives the serial clock, 1 = external serial clock |
| result | input | DATA_W | Parallel conversion word, sampled on each load |
| sclk_in | input | 1 | External serial clock, idles high |
| sclk_out | output | 1 | Generated serial clock, idles high |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| dout | output | 1 | Combined ready flag and serial data |
| dout_oe | output | 1 | Drive enable for the data pin |

## Verification
The checker watches the relationships that hold on every cycle. A load must pull `dout` low on the next cycle. A blanking cycle or a standby cycle must leave `dout` high with no word held. `dout` must be high whenever the held word is released. The generated clock must sit high whenever no word is held. The bench scenarios cover what a single cycle cannot show: the exact load period, the MSB-first bit order and the ready interval in self-clocked mode, burst and batched external reads giving the same word, unread and partly read words being dropped at the blanking window, clock pulses inside that window being ignored, and aborts through `cs_n` followed by a full new conversion.

// File: rtl/sdo_pkg.sv
// Shared definitions for the serial output port.
// Assumes: the mode pin is a static strap that changes only while cs_n is high.
package sdo_pkg;

    // Read-out clocking style chosen by the mode input.
    typedef enum logic {
        MODE_MASTER = 1'b0,
        MODE_SLAVE  = 1'b1
    } rd_mode_e;

    // Reset level of the serial clock and of the ready/data pin.
    localparam logic IDLE_LEVEL = 1'b1;

endpackage

// File: rtl/sdo_conv_timer.sv
// Abstract conversion timer. It counts a fixed conversion period while run is
// high, pulses load on the last cycle of each period, and raises blank for the
// BLANK_CYCLES cycles just before that load.
// Assumes: CONV_CYCLES > BLANK_CYCLES + 1; run low restarts the period.
module sdo_conv_timer #(
    parameter int CONV_CYCLES  = 400,
    parameter int BLANK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic load,
    output logic blank
);
    localparam int CW = $clog2(CONV_CYCLES);
    localparam logic [CW-1:0] LAST_CNT    = CW'(CONV_CYCLES - 1);
    localparam logic [CW-1:0] BLANK_START = CW'(CONV_CYCLES - 1 - BLANK_CYCLES);

    logic [CW-1:0] cnt;

    // Period counter: cleared in standby, wraps at the end of each conversion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST_CNT) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // Update strobe and the blanking window that precedes it.
    assign load  = run && (cnt == LAST_CNT);
    assign blank = run && (cnt >= BLANK_START) && (cnt != LAST_CNT);

endmodule

// File: rtl/sdo_edge_sync.sv
// Brings the external serial clock into the clk domain through SYNC_STAGES
// flops, then compares the last stage with one more flop to flag edges.
// Assumes: each level of the pin lasts longer than SYNC_STAGES + 1 cycles.
module sdo_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall,
    output logic rise
);
    localparam int SW = SYNC_STAGES + 1;

    logic [SW-1:0] sr;

    // Shift chain; reset to the idle-high level so that no edge is seen at start-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= {SW{sdo_pkg::IDLE_LEVEL}};
        end else begin
            sr <= {sr[SW-2:0], pin};
        end
    end

    // Edge flags from the synchronised level and its delayed copy.
    assign fall = sr[SW-1] && !sr[SW-2];
    assign rise = !sr[SW-1] && sr[SW-2];

endmodule

// File: rtl/sdo_master_clk.sv
// Self-clocked read-out generator. Once active, it waits RDY_HOLD cycles with
// the clock high, then toggles the clock every cycle and flags each edge it makes.
// Assumes: RDY_HOLD >= 1; active drops on the cycle after the last rising edge.
module sdo_master_clk #(
    parameter int RDY_HOLD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic sclk,
    output logic fall,
    output logic rise
);
    localparam int HW = $clog2(RDY_HOLD + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(RDY_HOLD);

    logic [HW-1:0] hold;
    logic          running;

    assign running = active && (hold == HOLD_END);

    // Ready interval counter, then clock toggling; parks high when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sclk <= sdo_pkg::IDLE_LEVEL;
            hold <= '0;
        end else if (!running) begin
            hold <= hold + HW'(1);
        end else begin
            sclk <= !sclk;
        end
    end

    // Edge flags that line up with the toggle this cycle.
    assign fall = running && sclk;
    assign rise = running && !sclk;

endmodule

// File: rtl/sdo_out_shifter.sv
// Output shift register and ready/data pin. A load parks the word and drives
// the pin low. A fall event shows the next bit MSB first. A rise event completes
// a bit, and the last one releases the word and drives the pin high. Blanking
// and standby drop the word.
// Assumes: fall and rise are never both high in one cycle.
module sdo_out_shifter #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              load,
    input  logic              blank,
    input  logic              fall,
    input  logic              rise,
    input  logic [DATA_W-1:0] word,
    output logic              dout,
    output logic              valid
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [BW-1:0]     bcnt;
    logic              half;

    // Word hold, bit shifting and pin level, with load > blank > read priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            shreg <= '0;
            valid <= 1'b0;
            dout  <= sdo_pkg::IDLE_LEVEL;
            half  <= 1'b0;
            bcnt  <= '0;
        end else if (load) begin
            shreg <= word;
            valid <= 1'b1;
            dout  <= 1'b0;
            half  <= 1'b0;
            bcnt  <= '0;
        end else if (blank) begin
            valid <= 1'b0;
            dout  <= sdo_pkg::IDLE_LEVEL;
            half  <= 1'b0;
        end else if (valid) begin
            if (fall) begin
                dout  <= shreg[DATA_W-1];
                shreg <= {shreg[DATA_W-2:0], 1'b0};
                half  <= 1'b1;
            end else if (rise && half) begin
                half <= 1'b0;
                if (bcnt == LAST_BIT) begin
                    valid <= 1'b0;
                    dout  <= sdo_pkg::IDLE_LEVEL;
                end else begin
                    bcnt <= bcnt + BW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/sdo_serial_port.sv
// Top of the serial output port. It ties together the conversion timer, the
// external clock synchroniser, the self-clocked generator and the shifter,
// selects the edge source by mode, and derives the pin drive enables from
// the select input.
// Assumes: slave_mode changes only in standby; clk is the oscillator-domain clock.
module sdo_serial_port #(
    parameter int DATA_W       = 24,
    parameter int CONV_CYCLES  = 400,
    parameter int BLANK_CYCLES = 16,
    parameter int RDY_HOLD     = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              slave_mode,
    input  logic [DATA_W-1:0] result,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              dout,
    output logic              dout_oe
);
    import sdo_pkg::*;

    rd_mode_e mode;
    logic     run;
    logic     load_w, blank_w, valid_w;
    logic     s_fall, s_rise, m_fall, m_rise, m_active;
    logic     fall_w, rise_w;

    assign mode = rd_mode_e'(slave_mode);
    assign run  = !cs_n;

    sdo_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES),
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .load (load_w),
        .blank(blank_w)
    );

    sdo_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sclk_in),
        .fall (s_fall),
        .rise (s_rise)
    );

    // Self-clocked read-out runs only while a word is held outside the blanking window.
    assign m_active = (mode == MODE_MASTER) && run && valid_w && !blank_w;

    sdo_master_clk #(
        .RDY_HOLD(RDY_HOLD)
    ) u_mclk (
        .clk   (clk),
        .rst_n (rst_n),
        .active(m_active),
        .sclk  (sclk_out),
        .fall  (m_fall),
        .rise  (m_rise)
    );

    // Edge source selected by the read-out mode.
    assign fall_w = (mode == MODE_SLAVE) ? s_fall : m_fall;
    assign rise_w = (mode == MODE_SLAVE) ? s_rise : m_rise;

    sdo_out_shifter #(
        .DATA_W(DATA_W)
    ) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .load (load_w),
        .blank(blank_w),
        .fall (fall_w),
        .rise (rise_w),
        .word (result),
        .dout (dout),
        .valid(valid_w)
    );

    // Pin drive enables: released at once in standby.
    assign dout_oe = run;
    assign sclk_oe = run && (mode == MODE_MASTER);

endmodule

// File: rtl/sdo_port_checker.sv
// Cycle-level properties of the serial output port, bound to the top module.
// Assumes: reset is held low from time zero until the design is initialised.
module sdo_port_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic load,
    input logic blank,
    input logic valid,
    input logic dout,
    input logic sclk_out
);
    // R3: a load pulls the pin low on the next cycle.
    p_ready_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !dout);

    // R6: a blanking cycle leaves the pin high and no word held.
    p_blank_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blank |=> (dout && !valid));

    // R1: standby leaves the pin register high and no word held.
    p_standby_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dout && !valid));

    // R5: whenever the held word is released, the pin is high.
    p_release_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> dout);

    // R7: the generated clock idles high when no word is held.
    p_sclk_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> sclk_out);
endmodule

bind sdo_serial_port sdo_port_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .load    (load_w),
    .blank   (blank_w),
    .valid   (valid_w),
    .dout    (dout),
    .sclk_out(sclk_out)
);

// File: tb/sdo_serial_port_tb.sv
module sdo_serial_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 24;
    localparam int C = 400;
    localparam int B = 16;
    localparam int H = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         slave_mode = 1'b0;
    logic         sclk_in = 1'b1;
    logic [W-1:0] result = '0;
    logic         sclk_out, sclk_oe, dout, dout_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    sdo_serial_port #(
        .DATA_W(W), .CONV_CYCLES(C), .BLANK_CYCLES(B), .RDY_HOLD(H), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .slave_mode(slave_mode),
        .result(result), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .dout(dout), .dout_oe(dout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Expected serial bit i (0 = first shifted) of a word.
    function automatic logic exp_bit(input logic [W-1:0] w, input int i);
        return w[W-1-i];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_to(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // Lower select and check the first load period; returns the load edge.
    task automatic start_conv(output int l_edge);
        int s;
        @(negedge clk);
        cs_n = 1'b0;
        s = cyc;
        #1;
        check("R1 dout_oe on select", 32'(dout_oe), 32'd1);
        check("R7/R8 sclk_oe by mode", 32'(sclk_oe), 32'(!slave_mode));
        wait_to(s + C - 1);
        check("R1 no stale ready before first load", 32'(dout), 32'd1);
        wait_to(s + C);
        check("R2 first load period", 32'(dout), 32'd0);
        l_edge = s + C;
    endtask

    // Self-clocked read of the word loaded at edge l.
    task automatic master_read(input int l, input logic [W-1:0] w);
        for (int k = 1; k <= H; k++) begin
            wait_to(l + k);
            check("R7 ready hold dout", 32'(dout), 32'd0);
            check("R7 ready hold sclk", 32'(sclk_out), 32'd1);
        end
        for (int i = 0; i < W; i++) begin
            wait_to(l + H + 2*i + 1);
            check("R7 sclk low phase", 32'(sclk_out), 32'd0);
            check("R4 bit after fall", 32'(dout), 32'(exp_bit(w, i)));
            wait_to(l + H + 2*i + 2);
            check("R7 sclk high phase", 32'(sclk_out), 32'd1);
            if (i < W-1) check("R4 bit held over rise", 32'(dout), 32'(exp_bit(w, i)));
            else         check("R5 high after last bit", 32'(dout), 32'd1);
        end
        wait_to(l + H + 2*W + 3);
        check("R5 stays high", 32'(dout), 32'd1);
        check("R7 sclk idles high", 32'(sclk_out), 32'd1);
    endtask

    // External clock pulses; collects bits sampled before each rise.
    task automatic slave_bits(input int n, inout logic [W-1:0] acc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sclk_in = 1'b0;
            repeat (4) @(negedge clk);
            acc = {acc[W-2:0], dout};
            sclk_in = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    // Wait for the next load at l+C and check the period; returns the new load edge.
    task automatic next_load(inout int l, output logic [W-1:0] w);
        wait_to(l + C - 1);
        check("R2 high before periodic load", 32'(dout), 32'd1);
        wait_to(l + C);
        check("R2 periodic load", 32'(dout), 32'd0);
        l = l + C;
        w = result;
        result = W'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int l;
        logic [W-1:0] w, acc;
        int g1, g2;
        void'($urandom(32'd7741));

        // Reset state
        repeat (3) @(negedge clk);
        check("R1 reset dout_oe", 32'(dout_oe), 32'd0);
        check("R1 reset sclk_oe", 32'(sclk_oe), 32'd0);
        check("R7 reset sclk high", 32'(sclk_out), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Self-clocked mode, directed corner words then random ones
        slave_mode = 1'b0;
        result = 24'h800001;
        start_conv(l);
        w = result; result = 24'hFFFFFF;
        master_read(l, w);
        next_load(l, w);
        master_read(l, w);
        result = 24'h000000;
        next_load(l, w);
        master_read(l, w);
        for (int k = 0; k < 3; k++) begin
            next_load(l, w);
            master_read(l, w);
        end

        // Abort mid self-clocked read
        wait_to(l + H + 9);
        cs_n = 1'b1;
        #1;
        check("R9 dout_oe drops at once", 32'(dout_oe), 32'd0);
        check("R9 sclk_oe drops at once", 32'(sclk_oe), 32'd0);
        repeat (3) @(negedge clk);
        start_conv(l);
        w = result; result = W'($urandom);
        master_read(l, w);

        // Externally clocked mode: burst read
        @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        slave_mode = 1'b1;
        result = W'($urandom);
        start_conv(l);
        w = result; result = W'($urandom);
        acc = '0;
        slave_bits(W, acc);
        check("R8 burst word", 32'(acc), 32'(w));
        check("R5 high after burst", 32'(dout), 32'd1);
        slave_bits(2, acc);
        check("R5 extra clocks ignored", 32'(dout), 32'd1);

        // Batched reads: fixed 8/8/8 then a random split with random gaps
        next_load(l, w);
        acc = '0;
        for (int g = 0; g < 3; g++) begin
            slave_bits(8, acc);
            repeat (12) @(negedge clk);
        end
        check("R8 three-group word", 32'(acc), 32'(w));
        for (int k = 0; k < 3; k++) begin
            next_load(l, w);
            acc = '0;
            g1 = 1 + int'($urandom % 10);
            g2 = 1 + int'($urandom % 10);
            slave_bits(g1, acc);
            repeat (1 + ($urandom % 20)) @(negedge clk);
            slave_bits(g2, acc);
            repeat (1 + ($urandom % 20)) @(negedge clk);
            slave_bits(W - g1 - g2, acc);
            check("R8 random-group word", 32'(acc), 32'(w));
            check("R5 high after groups", 32'(dout), 32'd1);
        end

        // Unread word dropped at the blanking window
        next_load(l, w);
        wait_to(l + C - B - 1);
        check("R6 unread still ready", 32'(dout), 32'd0);
        wait_to(l + C - B);
        check("R6 blank forces high", 32'(dout), 32'd1);

        // Clock pulse inside the blanking window is ignored
        wait_to(l + C - B + 1);
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R6 pulse in blank keeps high", 32'(dout), 32'd1);
        next_load(l, w);
        acc = '0;
        slave_bits(W, acc);
        check("R6 word intact after blank pulse", 32'(acc), 32'(w));

        // Partial read abandoned, then next word from its MSB
        next_load(l, w);
        acc = '0;
        slave_bits(10, acc);
        check("R10 partial bits", 32'(acc[9:0]), 32'(w[W-1:W-10]));
        wait_to(l + C - B);
        check("R10 partial dropped at blank", 32'(dout), 32'd1);
        next_load(l, w);
        acc = '0;
        slave_bits(W, acc);
        check("R10 next word from MSB", 32'(acc), 32'(w));

        // Abort mid external read
        next_load(l, w);
        acc = '0;
        slave_bits(5, acc);
        @(negedge clk);
        cs_n = 1'b1;
        #1;
        check("R9 dout_oe drops in external read", 32'(dout_oe), 32'd0);
        repeat (3) @(negedge clk);
        start_conv(l);
        w = result; result = W'($urandom);
        acc = '0;
        slave_bits(W, acc);
        check("R9 fresh word after abort", 32'(acc), 32'(w));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule